// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on an I2C-compatible two-wire bus that fronts a byte-wide internal memory held as a synchronous register array. SCL and SDA arrive as plain inputs and are oversampled by the system clock. The block synchronizes both lines and finds clock edges and START, repeated START and STOP conditions. It drives SDA only through an open-drain enable. When `sda_oe_o` is high, the pad pulls the line low.

A transaction opens with a header byte that carries a fixed device type, three select bits compared against strap pins, and a read/write flag. A write header is followed by two address bytes that load a persistent 14-bit current-address pointer, then by any number of data bytes. A read header streams bytes out from the current pointer. The pointer steps once per data byte, wraps at 14 bits, and survives STOP. A random read is a write header with the address bytes, then a repeated START and a read header.

A master-code byte puts the block in a high-speed state, which it reports on `hs_mode_o` until STOP. The storage depth is a parameter. With the default depth, pointer values alias onto the low index bits. Setting `MEM_AW` to 14 gives the full 16K x 8 array.

Top module: `tws_mem_slave`

## Requirements
- R1: The header byte after START is accepted and acknowledged only when bits 7..4 are 1010b and bits 3..1 equal `dev_sel_i`. Bit 0 set to 1 means read and 0 means write.
- R2: A header that does not match is not acknowledged. SDA then stays released for every later byte until the next START or STOP, and neither the pointer nor the memory changes.
- R3: After a write header, the next two bytes (high byte first) are acknowledged, and their 14 low bits load the pointer. Bits 15..14 are ignored.
- R4: Every data byte, written or read, uses the location at the pointer and then advances the pointer by one. The pointer is kept across STOP, so a later read header continues at the next location.
- R5: The pointer wraps from 3FFFh to 0000h, and a burst may cross the wrap with no limit on its length.
- R6: On a read, the slave drives 8 bits MSB first. On a master ACK (SDA low in the ninth bit) it sends the next byte. On a NACK it releases SDA and stays silent until START or STOP.
- R7: A write header with two address bytes, followed by a repeated START and a read header, reads from the newly loaded address.
- R8: There is no busy period. A header sent right after a write burst's STOP is acknowledged.
- R9: A first byte matching 00001xxxb sets `hs_mode_o` and is not acknowledged. The flag stays set through a repeated START and clears on STOP.
- R10: A START or STOP in the middle of a byte aborts it. A partly received data byte is never written, and a following header is handled normally.
- R11: After reset, `sda_oe_o` and `hs_mode_o` are low.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| dev_sel_i | input | 3 | Device-select strap compared with header bits 3..1 |
| sda_oe_o | output | 1 | Pull SDA low when high |
| hs_mode_o | output | 1 | High-speed state flag |

## Verification
Two functions can fall on the same SCL falling edge. The first is the pointer step, which on a write is paired with the memory write. The second is the start of the ACK drive. A burst that ends at 3FFFh puts the wrap on that same edge. The bench writes a burst across 3FFFh and reads it back with a random read, and it judges the edge by the bytes returned and by where a later current-address read resumes. A START or STOP on a partial byte, after earlier full bytes went through, provokes an abort beside a pending write. The bench judges it by reading back the old byte at that location.

// File: rtl/tws_mem_pkg.sv
package tws_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD, ST_IGN, ST_HS
  } st_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [4:0] HS_CODE  = 5'b00001;
endpackage

// File: rtl/tws_bus_sampler.sv
module tws_bus_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_s, sda_s;
  logic scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC-2:0], scl_i};
      sda_s <= {sda_s[SYNC-2:0], sda_i};
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  assign scl_q      = scl_s[SYNC-1];
  assign sda_q      = sda_s[SYNC-1];
  assign sda_o      = sda_q;
  assign scl_rise_o = scl_q & ~scl_p;
  assign scl_fall_o = ~scl_q & scl_p;
  assign start_o    = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_o     = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/tws_mem_array.sv
module tws_mem_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
  import tws_mem_pkg::*;
#(
  parameter int PTR_W       = 14,
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  output logic       sda_oe_o,
  output logic       hs_mode_o
);
  localparam int DW    = 8;
  localparam int CNT_W = 4;
  localparam int HI_W  = PTR_W - DW;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  tws_bus_sampler #(.SYNC(SYNC_STAGES)) u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  st_e             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]   shift_q, tx_q, ahi_q, rd_data;
  logic [PTR_W-1:0] ptr_q;
  logic            rw_q, mack_q, oe_q, hs_q;

  logic active, fall_act, bit8_fall, bit9_fall, hdr_match, hs_code;
  logic ptr_inc, mem_we;

  assign active    = (state_q != ST_IDLE) && (state_q != ST_IGN) && (state_q != ST_HS);
  assign fall_act  = scl_fall & active;
  assign bit8_fall = fall_act && (cnt_q == CNT_W'(8));
  assign bit9_fall = fall_act && (cnt_q == CNT_W'(9));
  assign hdr_match = (shift_q[7:4] == DEV_TYPE) && (shift_q[3:1] == dev_sel_i);
  assign hs_code   = (shift_q[7:3] == HS_CODE);
  assign ptr_inc   = bit8_fall && ((state_q == ST_WR) || (state_q == ST_RD));
  assign mem_we    = bit8_fall && (state_q == ST_WR);

  tws_mem_array #(.AW(MEM_AW), .DW(DW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(ptr_q[MEM_AW-1:0]),
    .wdata_i(shift_q),
    .raddr_i(ptr_q[MEM_AW-1:0]),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      ahi_q   <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      hs_q    <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      hs_q    <= 1'b0;
    end else begin
      if (scl_rise && active) begin
        if (cnt_q < CNT_W'(8)) begin
          shift_q <= {shift_q[DW-2:0], sda_s};
          cnt_q   <= cnt_q + 1'b1;
        end else if (cnt_q == CNT_W'(9)) begin
          mack_q <= ~sda_s;
        end
      end
      if (ptr_inc) ptr_q <= ptr_q + 1'b1;
      if (bit8_fall) begin
        cnt_q <= CNT_W'(9);
        unique case (state_q)
          ST_DEV: begin
            if (hdr_match) begin
              oe_q <= 1'b1;
              rw_q <= shift_q[0];
            end else if (hs_code) begin
              hs_q    <= 1'b1;
              state_q <= ST_HS;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_IGN;
              cnt_q   <= '0;
            end
          end
          ST_AHI: begin
            oe_q  <= 1'b1;
            ahi_q <= shift_q;
          end
          ST_ALO: begin
            oe_q  <= 1'b1;
            ptr_q <= {ahi_q[HI_W-1:0], shift_q};
          end
          ST_WR:   oe_q <= 1'b1;
          ST_RD:   oe_q <= 1'b0;
          default: ;
        endcase
      end else if (bit9_fall) begin
        cnt_q <= '0;
        oe_q  <= 1'b0;
        unique case (state_q)
          ST_DEV: begin
            if (rw_q) begin
              state_q <= ST_RD;
              tx_q    <= rd_data;
              oe_q    <= ~rd_data[DW-1];
            end else begin
              state_q <= ST_AHI;
            end
          end
          ST_AHI: state_q <= ST_ALO;
          ST_ALO: state_q <= ST_WR;
          ST_RD: begin
            if (mack_q) begin
              tx_q <= rd_data;
              oe_q <= ~rd_data[DW-1];
            end else begin
              state_q <= ST_IGN;
            end
          end
          default: ;
        endcase
      end else if (fall_act && (state_q == ST_RD) && (cnt_q != '0) && (cnt_q < CNT_W'(8))) begin
        tx_q <= {tx_q[DW-2:0], 1'b0};
        oe_q <= ~tx_q[DW-2];
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign hs_mode_o = hs_q;
endmodule

// File: rtl/tws_mem_slave_chk.sv
module tws_mem_slave_chk
  import tws_mem_pkg::*;
#(
  parameter int PTR_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             hs_mode_o,
  input logic             stop_i,
  input st_e              state_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic             ptr_inc_i,
  input logic             we_i
);
  a_r12_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  a_r9_stop_clears_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !hs_mode_o);

  a_r9_code_not_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HS) |-> !sda_oe_o);

  a_r2_ignore_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IGN) |-> !sda_oe_o);

  a_r5_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_inc_i && (ptr_i == '1)) |=> (ptr_i == '0));

  a_r4_write_steps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ptr_i == PTR_W'($past(ptr_i) + 1'b1)));
endmodule

bind tws_mem_slave tws_mem_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .hs_mode_o(hs_mode_o),
  .stop_i   (stop_det),
  .state_i  (state_q),
  .ptr_i    (ptr_q),
  .ptr_inc_i(ptr_inc),
  .we_i     (mem_we)
);

// File: tb/tws_mem_slave_test.sv
module tws_mem_slave_test;
  localparam int MAW = 10;
  localparam int H   = 6;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] dev = 3'b101;
  logic sda_oe, hs;
  wire  sda_line = sda_m & ~sda_oe;

  logic [7:0]  model [1 << MAW];
  logic [13:0] mptr;
  logic [7:0]  buf_d [16];
  int errs = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  tws_mem_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(dev), .sda_oe_o(sda_oe), .hs_mode_o(hs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic logic [7:0] hdr(input bit rw, input logic [2:0] sel);
    return {4'b1010, sel, rw};
  endfunction

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(2);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H / 2);
    acked = !sda_line;
    hw(H / 2); scl_m = 1'b0; hw(2);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw(H); scl_m = 1'b1; hw(H / 2); b = {b[6:0], sda_line}; hw(H / 2); scl_m = 1'b0; hw(2);
    end
    sda_m = !ack; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; hw(2); sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [15:0] a);
    bit k;
    send_byte(hdr(1'b0, dev), k); chk(k, "R1 write header ack", k, 1);
    send_byte(a[15:8], k);        chk(k, "R3 addr hi ack", k, 1);
    send_byte(a[7:0], k);         chk(k, "R3 addr lo ack", k, 1);
    mptr = a[13:0];
  endtask

  task automatic write_burst(input logic [15:0] a, input int n);
    bit k;
    start_c(); set_addr(a);
    for (int i = 0; i < n; i++) begin
      send_byte(buf_d[i], k); chk(k, "R3 data ack", k, 1);
      model[mptr[MAW-1:0]] = buf_d[i]; mptr++;
    end
    stop_c();
  endtask

  task automatic read_cur(input int n, input string req);
    bit k; logic [7:0] b;
    send_byte(hdr(1'b1, dev), k); chk(k, "R1 read header ack", k, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b === model[mptr[MAW-1:0]], req, b, model[mptr[MAW-1:0]]);
      mptr++;
    end
    chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
    stop_c();
  endtask

  task automatic read_rand(input logic [15:0] a, input int n, input string req);
    start_c(); set_addr(a); start_c(); read_cur(n, req);
  endtask

  initial begin
    bit k; logic [7:0] b; logic [15:0] a; int n;
    void'($urandom(32'd7));
    mptr = '0;
    hw(5);
    chk(sda_oe == 1'b0, "R11 oe reset", sda_oe, 0);
    chk(hs == 1'b0, "R11 hs reset", hs, 0);
    rst_n = 1'b1; hw(5);

    for (int i = 0; i < 5; i++) buf_d[i] = 8'hA0 + 8'(i * 17);
    write_burst(16'h0010, 5);
    start_c(); send_byte(hdr(1'b0, dev), k); chk(k, "R8 ack right after write", k, 1);
    send_byte(8'h00, k); send_byte(8'h10, k); mptr = 14'h0010;
    start_c(); read_cur(3, "R7 random read data");
    start_c(); read_cur(2, "R4 pointer kept across STOP");

    buf_d[0] = 8'h5A; buf_d[1] = 8'hC3; buf_d[2] = 8'h96;
    write_burst(16'hFFFF, 3);
    read_rand(16'h3FFF, 2, "R5 wrap 3FFF to 0000");

    start_c();
    send_byte(hdr(1'b0, dev ^ 3'b001), k); chk(!k, "R2 wrong select nack", k, 0);
    send_byte(hdr(1'b0, dev), k);           chk(!k, "R2 ignored byte nack", k, 0);
    send_byte(8'h00, k);                    chk(!k, "R2 ignored byte nack", k, 0);
    send_byte(8'h77, k);                    chk(!k, "R2 ignored byte nack", k, 0);
    stop_c();
    start_c(); read_cur(1, "R2 pointer and memory unchanged");

    buf_d[0] = 8'h3C; write_burst(16'h0020, 1);
    start_c(); set_addr(16'h0020); send_bits(8'hFF, 4); stop_c();
    start_c(); set_addr(16'h0020); send_bits(8'h00, 3);
    start_c(); send_byte(hdr(1'b1, dev), k); chk(k, "R10 header after mid-byte START", k, 1);
    recv_byte(1'b0, b); stop_c();
    chk(b === 8'h3C, "R10 partial byte not written", b, 8'h3C);
    read_rand(16'h0020, 1, "R10 partial byte not written");

    start_c(); send_byte(8'h0B, k);
    chk(!k, "R9 master code not acked", k, 0);
    chk(hs == 1'b1, "R9 hs set", hs, 1);
    mptr = 14'h0021; model[14'h21 & 14'h3FF] = model[10'h021];
    start_c(); set_addr(16'h0011);
    chk(hs == 1'b1, "R9 hs kept over repeated START", hs, 1);
    start_c(); read_cur(2, "R9 read in hs state");
    chk(hs == 1'b0, "R9 hs cleared on STOP", hs, 0);

    start_c(); send_byte(hdr(1'b1, dev), k); chk(k, "R6 read header ack", k, 1);
    recv_byte(1'b0, b); chk(b === model[mptr[MAW-1:0]], "R6 single byte", b, model[mptr[MAW-1:0]]);
    mptr++;
    send_byte(8'hFF, k); chk(!k, "R6 silent after NACK", k, 0);
    stop_c();

    for (int it = 0; it < 8; it++) begin
      a = 16'($urandom);
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) buf_d[i] = 8'($urandom);
      write_burst(a, n);
      read_rand(a, n, "R4 random burst readback");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule